// File: doc/BRIEF.md
# Three-Wire Control-Port Master Sequencer

This block drives a three-wire control bus (mode, clock, data) from the controller side. It issues register writes and register reads to one slave. A host presents a command (write or read), a 7-bit register address, a 16-bit write word and a one-bit slave select, then pulses `start`. The engine serializes the bytes the transaction needs, switches the mode line between address-byte and data-byte phases, and makes the bus clock with a divider.

A write is four bytes: a device-address byte, a register byte with a leading 0, the upper data byte and then the lower data byte. A read has two phases. First comes the prepare phase: the device-address byte, then a register byte with a leading 1. Then comes the read phase: a second device-address byte whose two leading bits are 1,1, after which the engine releases the data line and receives three bytes. The first returned byte holds a validity bit and the echoed register address; the next two hold the data. The engine compares the echo with the requested address and flags an error on a mismatch or on a set invalid bit.

The controller is built around a four-state machine. The states are `ST_IDLE`, `ST_LOW` (bus clock low, data driven), `ST_HIGH` (bus clock high, slave samples) and `ST_GAP` (one idle bus-clock period between bytes). The transitions are:
- IDLE to LOW on `start`.
- LOW to HIGH on a divider tick.
- HIGH to LOW on a tick within a byte.
- HIGH to GAP on a tick after bit 7 of a byte that is not the last.
- GAP to LOW after two ticks.
- HIGH to IDLE after bit 7 of the last byte, which raises `done`.

Top module: `tw_ctrl_master`

## Requirements
- R1: After reset the block is idle: `busy`=0, `done`=0, `bus_clk`=1, `bus_mode`=1, `bus_oe`=0, `rd_data`=0, `rd_err`=0.
- R2: A write sends 32 bits, each bit's value taken on a rising `bus_clk` edge. The bytes go out in this order, each listed in time order: 0,1,SEL,0,1,0,0,0; then 0,A6..A0; then D15..D8; then D7..D0.
- R3: A read sends 24 bits and then receives 24 bits. The sent bytes, each listed in time order: 0,1,SEL,0,1,0,0,0; then 1,A6..A0; then 1,1,SEL,0,1,0,0,0.
- R4: `bus_mode` is 0 on every bit of a device-address byte and 1 on every other byte.
- R5: Each bus-clock half period lasts CLK_HALF cycles, and consecutive bytes are separated by one full bus-clock period with the clock high. `done` is therefore high 70·CLK_HALF cycles after the edge that takes `start` for a write, and 106·CLK_HALF cycles after it for a read. Data and mode never change while `bus_clk` is low.
- R6: `bus_oe` is 0 during the three response bytes and 1 during all sent bytes. The engine samples `bus_din` on each rising `bus_clk` edge.
- R7: After a read, `rd_data` equals the second and third returned bytes, the upper byte first and each byte MSB first. A write leaves `rd_data` unchanged.
- R8: `rd_err` is 1 after a read if the first bit returned is 1 (invalid) or if the echoed A6..A0 differs from the requested address. Otherwise it is 0. A write clears it.
- R9: `start` is ignored while `busy` is 1: the transaction in progress, its frame and its timing are unchanged.
- R10: `done` is a single-cycle pulse, and `busy` is 0 in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transaction (ignored while busy) |
| cmd_read | input | 1 | 1 = read, 0 = write |
| reg_addr | input | 7 | Register address |
| wr_data | input | 16 | Write word |
| sel | input | 1 | Slave select bit placed in the device-address byte |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse at the end of a transaction |
| rd_data | output | 16 | Last word read |
| rd_err | output | 1 | Invalid or mismatched echo on the last read |
| bus_mode | output | 1 | Mode line: 0 address byte, 1 other bytes |
| bus_clk | output | 1 | Bus clock, idles high |
| bus_dout | output | 1 | Serial data out |
| bus_oe | output | 1 | Data-line output enable |
| bus_din | input | 1 | Serial data in from the slave |

## Verification
The result of a write, `done`, is due exactly 70·CLK_HALF clock edges after the edge that takes `start`. For a read it is due 106·CLK_HALF edges after that edge, and `rd_data` and `rd_err` are valid in the same cycle as `done`. The bench counts rising edges from the edge where `start` is taken and samples on the falling edge, so a difference of one cycle is reported. The bench's slave model records mode, output enable and data at each rising bus-clock edge, and presents response bits at each falling bus-clock edge. The frame is therefore checked bit by bit against bytes the bench builds from the requirement encodings.

// File: rtl/tw_pkg.sv
package tw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_GAP
    } tw_state_e;

    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 7;
    localparam int DATA_W  = 16;
    localparam int IDX_W   = 3;
    localparam int BIT_W   = $clog2(BYTE_W);
    localparam int RX_W    = 3 * BYTE_W;
    // device-address byte tail after the two leading bits and SEL
    localparam logic [4:0] DEV_TAIL = 5'b01000;
endpackage

// File: rtl/tw_tick.sv
module tw_tick #(
    parameter int CLK_HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_HALF - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/tw_byte_plan.sv
module tw_byte_plan
    import tw_pkg::*;
(
    input  logic                 is_read,
    input  logic [IDX_W-1:0]     idx,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    data,
    input  logic                 sel,
    output logic [BYTE_W-1:0]    tx_byte,
    output logic                 mode,
    output logic                 rx,
    output logic                 last
);
    always_comb begin
        tx_byte = '0;
        mode    = 1'b1;
        rx      = 1'b0;
        unique case (idx)
            3'd0: begin
                tx_byte = {2'b01, sel, DEV_TAIL};
                mode    = 1'b0;
            end
            3'd1: tx_byte = {is_read, addr};
            3'd2: begin
                if (is_read) begin
                    tx_byte = {2'b11, sel, DEV_TAIL};
                    mode    = 1'b0;
                end else begin
                    tx_byte = data[DATA_W-1 -: BYTE_W];
                end
            end
            3'd3: begin
                if (is_read) rx = 1'b1;
                else         tx_byte = data[BYTE_W-1:0];
            end
            default: rx = 1'b1;
        endcase
        last = is_read ? (idx == 3'd5) : (idx == 3'd3);
    end
endmodule

// File: rtl/tw_ctrl_master.sv
module tw_ctrl_master
    import tw_pkg::*;
#(
    parameter int CLK_HALF = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cmd_read,
    input  logic [6:0]        reg_addr,
    input  logic [15:0]       wr_data,
    input  logic              sel,
    output logic              busy,
    output logic              done,
    output logic [15:0]       rd_data,
    output logic              rd_err,
    output logic              bus_mode,
    output logic              bus_clk,
    output logic              bus_dout,
    output logic              bus_oe,
    input  logic              bus_din
);
    tw_state_e state_q, state_d;

    logic [BIT_W-1:0]  bit_q;
    logic [IDX_W-1:0]  idx_q;
    logic              gap_q;
    logic              req_read_q;
    logic [ADDR_W-1:0] req_addr_q;
    logic [DATA_W-1:0] req_data_q;
    logic              req_sel_q;
    logic [RX_W-1:0]   rx_q;

    logic              tick;
    logic [BYTE_W-1:0] plan_byte;
    logic              plan_mode, plan_rx, plan_last;

    tw_tick #(.CLK_HALF(CLK_HALF)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q != ST_IDLE),
        .tick  (tick)
    );

    tw_byte_plan u_plan (
        .is_read (req_read_q),
        .idx     (idx_q),
        .addr    (req_addr_q),
        .data    (req_data_q),
        .sel     (req_sel_q),
        .tx_byte (plan_byte),
        .mode    (plan_mode),
        .rx      (plan_rx),
        .last    (plan_last)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_LOW;
            ST_LOW:  if (tick)  state_d = ST_HIGH;
            ST_HIGH: if (tick) begin
                if (bit_q != BIT_W'(BYTE_W - 1)) state_d = ST_LOW;
                else if (plan_last)              state_d = ST_IDLE;
                else                             state_d = ST_GAP;
            end
            ST_GAP:  if (tick && gap_q) state_d = ST_LOW;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q      <= '0;
            idx_q      <= '0;
            gap_q      <= 1'b0;
            req_read_q <= 1'b0;
            req_addr_q <= '0;
            req_data_q <= '0;
            req_sel_q  <= 1'b0;
            rx_q       <= '0;
            rd_data    <= '0;
            rd_err     <= 1'b0;
            done       <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (start) begin
                    req_read_q <= cmd_read;
                    req_addr_q <= reg_addr;
                    req_data_q <= wr_data;
                    req_sel_q  <= sel;
                    bit_q      <= '0;
                    idx_q      <= '0;
                    gap_q      <= 1'b0;
                end
                ST_LOW: if (tick && plan_rx)
                    rx_q <= {rx_q[RX_W-2:0], bus_din};
                ST_HIGH: if (tick) begin
                    if (bit_q != BIT_W'(BYTE_W - 1)) begin
                        bit_q <= bit_q + 1'b1;
                    end else if (plan_last) begin
                        done <= 1'b1;
                        if (req_read_q) begin
                            rd_data <= rx_q[DATA_W-1:0];
                            rd_err  <= rx_q[RX_W-1] |
                                       (rx_q[RX_W-2 -: ADDR_W] != req_addr_q);
                        end else begin
                            rd_err  <= 1'b0;
                        end
                    end else begin
                        idx_q <= idx_q + 1'b1;
                        bit_q <= '0;
                        gap_q <= 1'b0;
                    end
                end
                ST_GAP: if (tick) gap_q <= 1'b1;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy     = (state_q != ST_IDLE);
        bus_clk  = (state_q != ST_LOW);
        bus_mode = busy ? plan_mode : 1'b1;
        bus_oe   = busy && !plan_rx;
        bus_dout = busy ? plan_byte[BIT_W'(BYTE_W - 1) - bit_q] : 1'b1;
    end

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(req_addr_q) && $stable(req_read_q) && $stable(req_data_q)));

    assert_low_phase_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_clk && $past(!bus_clk)) |-> ($stable(bus_dout) && $stable(bus_mode)));

    assert_rx_mode_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !bus_oe) |-> bus_mode);

    assert_write_clears_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !req_read_q) |-> !rd_err);
endmodule

// File: tb/test_tw_ctrl_master.sv
module test_tw_ctrl_master;
    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        cmd_read = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic [15:0] wr_data = '0;
    logic        sel = 1'b0;
    logic        busy, done, rd_err, bus_mode, bus_clk, bus_dout, bus_oe;
    logic [15:0] rd_data;
    bit          bus_din;

    int n_checks = 0;
    int n_fail   = 0;

    // slave model state
    bit          cap_en = 1'b0;
    int          txn_id = 0;
    int          seen_id = 0;
    int          ncap = 0;
    logic [23:0] resp_word = '0;
    logic        cap_mode [64];
    logic        cap_oe   [64];
    logic        cap_bit  [64];

    always #2 clk = ~clk;   // 250 MHz

    tw_ctrl_master #(.CLK_HALF(HALF)) i_tw_ctrl_master (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_read(cmd_read),
        .reg_addr(reg_addr), .wr_data(wr_data), .sel(sel), .busy(busy),
        .done(done), .rd_data(rd_data), .rd_err(rd_err), .bus_mode(bus_mode),
        .bus_clk(bus_clk), .bus_dout(bus_dout), .bus_oe(bus_oe), .bus_din(bus_din)
    );

    always @(posedge bus_clk) begin
        if (cap_en) begin
            if (seen_id != txn_id) begin
                ncap    = 0;
                seen_id = txn_id;
            end
            if (ncap < 64) begin
                cap_mode[ncap] = bus_mode;
                cap_oe[ncap]   = bus_oe;
                cap_bit[ncap]  = bus_dout;
            end
            ncap = ncap + 1;
        end
    end

    always @(negedge bus_clk) begin
        if (cap_en && !bus_oe && ncap >= 24 && ncap < 48)
            bus_din = resp_word[47 - ncap];
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_txn(input logic rd, input logic [6:0] a, input logic [15:0] d,
                           input logic s, input logic [23:0] resp, input bit inject);
        logic [7:0]  bytes [6];
        logic [15:0] prev_rd;
        int          cycles;
        int          nbits;
        int          bad_bit, bad_mode, bad_oe;
        string       rq;
        prev_rd = rd_data;
        bytes[0] = {2'b01, s, 5'b01000};
        bytes[1] = {rd, a};
        bytes[2] = rd ? {2'b11, s, 5'b01000} : d[15:8];
        bytes[3] = rd ? 8'h00 : d[7:0];
        bytes[4] = 8'h00;
        bytes[5] = 8'h00;
        nbits = rd ? 48 : 32;
        rq = rd ? "R3" : "R2";

        @(negedge clk);
        resp_word = resp;
        txn_id++;
        cmd_read = rd; reg_addr = a; wr_data = d; sel = s; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        cycles = 0;
        forever begin
            @(posedge clk);
            cycles++;
            @(negedge clk);
            if (inject) begin
                // R9: start pulse with other values while busy
                start    = (cycles == 40);
                cmd_read = ~rd; reg_addr = ~a; wr_data = ~d; sel = ~s;
            end
            if (done || cycles > 2000) break;
        end
        start = 1'b0; cmd_read = rd; reg_addr = a; wr_data = d; sel = s;
        check("R5", "cycles to done", cycles, (rd ? 106 : 70) * HALF);

        if (rd) begin
            check("R7", "rd_data", {16'h0, rd_data}, {16'h0, resp[15:0]});
            check("R8", "rd_err", {31'h0, rd_err},
                  {31'h0, resp[23] | (resp[22:16] != a)});
        end else begin
            check("R7", "rd_data kept on write", {16'h0, rd_data}, {16'h0, prev_rd});
            check("R8", "rd_err cleared on write", {31'h0, rd_err}, 32'h0);
        end

        @(posedge clk);
        @(negedge clk);
        check("R10", "done/busy after pulse", {30'h0, done, busy}, 32'h0);

        check(rq, "bit count", ncap, nbits);
        bad_bit = 0; bad_mode = 0; bad_oe = 0;
        for (int i = 0; i < nbits && i < 64; i++) begin
            int  bi = i / 8;
            bit  is_rx = rd && bi >= 3;
            bit  is_dev = (bi == 0) || (rd && bi == 2);
            if (!is_rx && cap_bit[i] !== bytes[bi][7 - (i % 8)]) bad_bit++;
            if (cap_mode[i] !== !is_dev) bad_mode++;
            if (cap_oe[i] !== !is_rx) bad_oe++;
        end
        check(rq, "frame bit mismatches", bad_bit, 0);
        check("R4", "mode mismatches", bad_mode, 0);
        check("R6", "oe mismatches", bad_oe, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "busy", {31'h0, busy}, 32'h0);
        check("R1", "done", {31'h0, done}, 32'h0);
        check("R1", "bus_clk", {31'h0, bus_clk}, 32'h1);
        check("R1", "bus_mode", {31'h0, bus_mode}, 32'h1);
        check("R1", "bus_oe", {31'h0, bus_oe}, 32'h0);
        check("R1", "rd_data", {16'h0, rd_data}, 32'h0);
        check("R1", "rd_err", {31'h0, rd_err}, 32'h0);
        rst_n = 1'b1;
        cap_en = 1'b1;
        @(negedge clk);

        // R2: write sweep over every register address
        for (int a = 0; a < 128; a++)
            run_txn(1'b0, 7'(a), 16'((a * 16'h0b3d) ^ 16'h5a0f), 1'(a % 2), 24'h0, 1'b0);

        // R3/R7/R8: reads with valid echo, invalid bit, mismatched echo
        for (int k = 0; k < 8; k++) begin
            logic [6:0]  ra = 7'((k * 37) + 5);
            logic [15:0] dv = 16'((k * 16'h1357) ^ 16'hc3a5);
            logic        inv = (k % 4 == 1);
            logic [6:0]  echo = (k % 4 == 2) ? (ra ^ 7'h10) : ra;
            run_txn(1'b1, ra, dv, 1'(k % 2), {inv, echo, dv}, 1'b0);
        end
        // both flags together and edge addresses
        run_txn(1'b1, 7'h7f, 16'hffff, 1'b1, {1'b1, 7'h00, 16'hffff}, 1'b0);
        run_txn(1'b1, 7'h00, 16'h0000, 1'b0, {1'b0, 7'h00, 16'h0001}, 1'b0);

        // R7/R8: a write after a read keeps rd_data, clears rd_err
        run_txn(1'b1, 7'h22, 16'h0, 1'b0, {1'b1, 7'h22, 16'hbeef}, 1'b0);
        run_txn(1'b0, 7'h22, 16'h1234, 1'b0, 24'h0, 1'b0);

        // R9: start while busy, write and read
        run_txn(1'b0, 7'h15, 16'ha5c3, 1'b1, 24'h0, 1'b1);
        run_txn(1'b1, 7'h6a, 16'h0, 1'b0, {1'b0, 7'h6a, 16'h7e81}, 1'b1);
        repeat (20) @(negedge clk);
        check("R9", "idle after ignored start", {31'h0, busy}, 32'h0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule